// File: doc/BRIEF.md
# Second-Order Sigma-Delta Bit-Stream Modulator

This block converts a stream of signed 16-bit samples into a one-bit stream. Each sample period is marked by a clock-enable strobe. On each strobe the input is first scaled by a programmable gain. The result then passes through two saturating accumulators in cascade. A sign decision on the second accumulator closes the loop: the previous decision is fed back into both accumulators as plus or minus full scale, and each of the two paths has its own programmable weight.

The two loop weights set the poles of the signal path. That path is an all-pole lowpass response, and the noise path is a highpass response with the same two poles. The input gain is normally set equal to the first loop weight, which gives the signal path a DC gain of one. With that setting, a constant input yields a repeating bit pattern whose long-term mean, read as plus or minus 32768, equals the input word. A lowpass reconstruction stage outside the block recovers the signal.

Top module: `sd_mod2_top`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators are cleared to zero and `bit_out` is 0 after that edge.
- R2: The state and `bit_out` change only on edges where `smp_en` is high. Changes to `din`, `gain_in`, `coef_a` or `coef_b` between strobes have no effect until the next strobe.
- R3: The scaled input is floor(din * gain_in / 2^14), with `din` signed and `gain_in` an unsigned Q2.14 value (16384 means 1.0).
- R4: The feedback level is +32768 when the current `bit_out` is 1 and -32768 when it is 0. The first accumulator is updated as acc1 + scaled - floor(coef_a * fb / 2^14), with `coef_a` an unsigned Q2.14 value.
- R5: The second accumulator is updated as acc2 + acc1_old - floor(coef_b * fb / 2^14). It uses the first accumulator's value from before the same strobe, and `coef_b` is an unsigned Q2.14 value.
- R6: On each strobe, `bit_out` becomes 1 when the updated second accumulator is zero or positive, and 0 when it is negative.
- R7: Both accumulators are 24-bit signed. Each saturates at 8388607 and -8388608 and never wraps.
- R8: With coef_a = gain_in = 0.5 and coef_b = 1.0 (poles at radius 0.707, inside the unit circle), a DC input gives a bit-stream mean, read as plus or minus 32768, that lies within 400 of `din` over a 2048-sample window.
- R9: Coefficient and gain values present on the strobe edge itself are used for that strobe's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe, one update per high cycle |
| din | input | 16 | Signed input sample |
| gain_in | input | 16 | Input pre-scale, unsigned Q2.14 |
| coef_a | input | 16 | Feedback weight into first accumulator, unsigned Q2.14 |
| coef_b | input | 16 | Feedback weight into second accumulator, unsigned Q2.14 |
| bit_out | output | 1 | Modulated one-bit stream |

## Verification
Two events can fall on the same edge: a coefficient or gain change, and a sample strobe. The bench provokes this by rewriting `coef_a` and `gain_in` in exactly the strobe cycles. It judges the result bit for bit against a model that reads the values present at that edge. A second collision occurs when both accumulators clip in the same update while the decision flips. The bench drives the largest gain with the loop weights at zero, so both integrators run into their rails. It then reverses the input, where any wrap instead of a clip would show up as early sign changes in the compared stream.

// File: rtl/sd_mod2_pkg.sv
package sd_mod2_pkg;
  localparam int SD_DATA_W = 16;
  localparam int SD_COEF_W = 16;
  localparam int SD_FRAC_W = 14;
  localparam int SD_ACC_W  = 24;

  typedef enum logic {
    DEC_LOW  = 1'b0,
    DEC_HIGH = 1'b1
  } sd_dec_e;
endpackage

// File: rtl/sd_prescale.sv
module sd_prescale #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter int OUT_W  = DATA_W + COEF_W + 1 - FRAC_W
) (
  input  logic signed [DATA_W-1:0] x_in,
  input  logic        [COEF_W-1:0] gain,
  output logic signed [OUT_W-1:0]  scaled
);
  localparam int PW = DATA_W + COEF_W + 1;

  // signed sample times unsigned fixed-point gain, floored
  function automatic logic signed [PW-1:0] apply_gain(
    input logic signed [DATA_W-1:0] x,
    input logic        [COEF_W-1:0] g
  );
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] ge;
    logic signed [PW-1:0] pr;
    xe = {{(COEF_W+1){x[DATA_W-1]}}, x};
    ge = {{(DATA_W+1){1'b0}}, g};
    pr = xe * ge;
    return pr >>> FRAC_W;
  endfunction

  logic signed [PW-1:0] full;

  always_comb begin
    full   = apply_gain(x_in, gain);
    scaled = full[OUT_W-1:0];
  end
endmodule

// File: rtl/sd_integrator.sv
module sd_integrator #(
  parameter int ACC_W   = 24,
  parameter int IN_W    = 19,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int FS_LOG2 = 15,
  parameter int EXT_W   = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  add_in,
  input  logic        [COEF_W-1:0] coef,
  input  logic                    fb_bit,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_d,
  output logic signed [EXT_W-1:0] delta,
  output logic                    sat_hi,
  output logic                    sat_lo
);
  localparam int PROD_W = COEF_W + FS_LOG2 + 1;
  localparam logic signed [EXT_W-1:0] MAXV =
    {{(EXT_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] MINV =
    {{(EXT_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // weight times the +/- full-scale feedback level, floored
  function automatic logic signed [EXT_W-1:0] fb_weight(
    input logic [COEF_W-1:0] c,
    input logic              b
  );
    logic signed [PROD_W-1:0] p;
    p = {{(FS_LOG2+1){1'b0}}, c};
    p = p <<< FS_LOG2;
    if (!b) p = -p;
    p = p >>> FRAC_W;
    return p[EXT_W-1:0];
  endfunction

  function automatic logic signed [ACC_W-1:0] clip(
    input logic signed [EXT_W-1:0] v
  );
    if (v > MAXV) return ACC_MAX;
    else if (v < MINV) return ACC_MIN;
    else return v[ACC_W-1:0];
  endfunction

  logic signed [EXT_W-1:0] acc_x;
  logic signed [EXT_W-1:0] in_x;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    acc_x  = {{(EXT_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    in_x   = {{(EXT_W-IN_W){add_in[IN_W-1]}}, add_in};
    delta  = in_x - fb_weight(coef, fb_bit);
    sum    = acc_x + delta;
    sat_hi = (sum > MAXV);
    sat_lo = (sum < MINV);
    acc_d  = clip(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/sd_decision.sv
module sd_decision
  import sd_mod2_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc_next,
  output logic                    bit_q
);
  sd_dec_e dec_q;
  sd_dec_e dec_d;

  always_comb dec_d = acc_next[ACC_W-1] ? DEC_LOW : DEC_HIGH;

  always_ff @(posedge clk) begin
    if (rst) dec_q <= DEC_LOW;
    else if (en) dec_q <= dec_d;
  end

  assign bit_q = (dec_q == DEC_HIGH);
endmodule

// File: rtl/sd_mod2_top.sv
module sd_mod2_top
  import sd_mod2_pkg::*;
#(
  parameter int DATA_W = SD_DATA_W,
  parameter int COEF_W = SD_COEF_W,
  parameter int FRAC_W = SD_FRAC_W,
  parameter int ACC_W  = SD_ACC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic        [COEF_W-1:0] gain_in,
  input  logic        [COEF_W-1:0] coef_a,
  input  logic        [COEF_W-1:0] coef_b,
  output logic                     bit_out
);
  localparam int SC_W    = DATA_W + COEF_W + 1 - FRAC_W;
  localparam int EXT_W   = ACC_W + 2;
  localparam int FS_LOG2 = DATA_W - 1;

  logic signed [SC_W-1:0]  scaled;
  logic signed [ACC_W-1:0] acc1_q, acc1_d, acc2_q, acc2_d;
  logic signed [EXT_W-1:0] delta1, delta2;
  logic                    sat1_hi, sat1_lo, sat2_hi, sat2_lo;

  sd_prescale #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .OUT_W(SC_W)
  ) u_pre (
    .x_in(din), .gain(gain_in), .scaled(scaled)
  );

  sd_integrator #(
    .ACC_W(ACC_W), .IN_W(SC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .FS_LOG2(FS_LOG2), .EXT_W(EXT_W)
  ) u_int1 (
    .clk(clk), .rst(rst), .en(smp_en), .add_in(scaled), .coef(coef_a),
    .fb_bit(bit_out), .acc_q(acc1_q), .acc_d(acc1_d), .delta(delta1),
    .sat_hi(sat1_hi), .sat_lo(sat1_lo)
  );

  sd_integrator #(
    .ACC_W(ACC_W), .IN_W(ACC_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .FS_LOG2(FS_LOG2), .EXT_W(EXT_W)
  ) u_int2 (
    .clk(clk), .rst(rst), .en(smp_en), .add_in(acc1_q), .coef(coef_b),
    .fb_bit(bit_out), .acc_q(acc2_q), .acc_d(acc2_d), .delta(delta2),
    .sat_hi(sat2_hi), .sat_lo(sat2_lo)
  );

  sd_decision #(.ACC_W(ACC_W)) u_dec (
    .clk(clk), .rst(rst), .en(smp_en), .acc_next(acc2_d), .bit_q(bit_out)
  );
endmodule

// File: rtl/sd_mod2_checker.sv
module sd_mod2_checker #(
  parameter int ACC_W = 24,
  parameter int EXT_W = ACC_W + 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    bit_out,
  input logic signed [ACC_W-1:0] acc1,
  input logic signed [ACC_W-1:0] acc2,
  input logic signed [EXT_W-1:0] d1,
  input logic signed [EXT_W-1:0] d2
);
  localparam logic signed [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (bit_out == 1'b0 && acc1 == '0 && acc2 == '0));

  // R2
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(bit_out) && $stable(acc1) && $stable(acc2)));

  // R6
  assert_decision_sign_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> (bit_out == !acc2[ACC_W-1]));

  // R7
  assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !acc1[ACC_W-1] && !d1[EXT_W-1]) |=> !acc1[ACC_W-1]);

  // R7
  assert_no_wrap_down_R7: assert property (@(posedge clk) disable iff (rst)
    (en && acc2[ACC_W-1] && d2[EXT_W-1]) |=> acc2[ACC_W-1]);

  // R7
  assert_rail_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en && acc1 == AMAX && !d1[EXT_W-1]) |=> (acc1 == AMAX));
endmodule

bind sd_mod2_top sd_mod2_checker #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .en(smp_en), .bit_out(bit_out),
  .acc1(acc1_q), .acc2(acc2_q), .d1(delta1), .d2(delta2)
);

// File: tb/test_sd_mod2_top.sv
`timescale 1ns/1ps
module test_sd_mod2_top;
  logic               clk = 1'b0;
  logic               rst;
  logic               smp_en;
  logic signed [15:0] din;
  logic        [15:0] gain_in, coef_a, coef_b;
  logic               bit_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  string req     = "R1";

  longint m_a1, m_a2;
  bit     m_y;

  always #2 clk = ~clk;

  sd_mod2_top i_sd_mod2_top (
    .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
    .gain_in(gain_in), .coef_a(coef_a), .coef_b(coef_b), .bit_out(bit_out)
  );

  function automatic longint lim(input longint v);
    if (v > 64'sd8388607) return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  // behavioural reference of the difference equations
  always @(posedge clk) begin : model
    longint fb, xs, n1, n2;
    if (rst) begin
      m_a1 = 0; m_a2 = 0; m_y = 1'b0;
    end else if (smp_en) begin
      fb = m_y ? 64'sd32768 : -64'sd32768;
      xs = (longint'(din) * longint'(gain_in)) >>> 14;
      n1 = lim(m_a1 + xs - ((longint'(coef_a) * fb) >>> 14));
      n2 = lim(m_a2 + m_a1 - ((longint'(coef_b) * fb) >>> 14));
      m_a1 = n1; m_a2 = n2; m_y = (n2 >= 0);
    end
  end

  task automatic check(input bit ok, input string r, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  // called at a negedge: advance one clock and compare against the model
  task automatic cyc();
    @(negedge clk);
    check(bit_out == m_y, req, bit_out, m_y);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin : stim
    longint acc_sum;
    rst = 1'b1; smp_en = 1'b1; din = 16'sd12345;
    gain_in = 16'd8192; coef_a = 16'd8192; coef_b = 16'd16384;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R1: output low under reset even with strobe and input active
    check(bit_out == 1'b0, "R1 reset output", bit_out, 0);
    rst = 1'b0;

    // R3 R4 R5 R6: strobe every cycle, triangle sweep
    req = "R3 R4 R5 R6 sweep";
    for (int i = 0; i < 600; i++) begin
      din = 16'(((i % 200) < 100) ? (i % 200) * 600 - 30000 : 30000 - ((i % 200) - 100) * 600);
      cyc();
    end

    // R2: sparse strobes, inputs and weights scrambled between strobes
    req = "R2 hold between strobes";
    for (int i = 0; i < 900; i++) begin
      smp_en = (i % 3 == 0);
      if (smp_en) begin
        din = 16'($urandom_range(0, 40000) - 20000);
        gain_in = 16'd8192; coef_a = 16'd8192; coef_b = 16'd16384;
      end else begin
        din = 16'($urandom);
        gain_in = 16'($urandom); coef_a = 16'($urandom); coef_b = 16'($urandom);
      end
      cyc();
    end
    smp_en = 1'b1;

    // R1: mid-run reset, then restart must match a cleared model
    req = "R1 restart";
    rst = 1'b1; din = 16'sd5000;
    gain_in = 16'd8192; coef_a = 16'd8192; coef_b = 16'd16384;
    @(negedge clk);
    check(bit_out == 1'b0, "R1 mid-run reset output", bit_out, 0);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) cyc();

    // R8: DC averages
    for (int k = 0; k < 3; k++) begin
      din = (k == 0) ? 16'sd10000 : ((k == 1) ? -16'sd20000 : 16'sd0);
      req = "R8 DC run";
      for (int i = 0; i < 64; i++) cyc();
      acc_sum = 0;
      for (int i = 0; i < 2048; i++) begin
        cyc();
        acc_sum += bit_out ? 32768 : -32768;
      end
      acc_sum = acc_sum / 2048;
      check((acc_sum - longint'(din) <= 400) && (longint'(din) - acc_sum <= 400),
            "R8 DC mean", acc_sum, longint'(din));
    end

    // R9: weights and gain change exactly on strobe edges
    req = "R9 same-edge update";
    for (int i = 0; i < 400; i++) begin
      smp_en = (i % 2 == 0);
      coef_a = (i % 4 == 0) ? 16'd8192 : 16'd7000;
      gain_in = coef_a;
      coef_b = (i % 8 < 4) ? 16'd16384 : 16'd15000;
      din = 16'sd7000;
      cyc();
    end
    smp_en = 1'b1;

    // R7: rails reached with loop weights at zero, then reversed
    req = "R7 saturation";
    coef_a = 16'd0; coef_b = 16'd0; gain_in = 16'hFFFF; din = 16'sd32767;
    for (int i = 0; i < 120; i++) cyc();
    check(bit_out == 1'b1, "R7 pinned high", bit_out, 1);
    din = -16'sd32768;
    for (int i = 0; i < 300; i++) cyc();
    check(bit_out == 1'b0, "R7 recovers low", bit_out, 0);
    din = 16'sd32767;
    for (int i = 0; i < 300; i++) cyc();

    summary();
    $finish;
  end
endmodule